// File: doc/BRIEF.md
# Fail-Safe System Clock Source Selector

This block picks the oscillator that drives each of three system clocks: an auxiliary clock, a main (processor) clock and a subsystem (peripheral) clock. Software writes a 3-bit source code for each clock. The block holds those codes in registers that take their default values at reset. It then resolves each code into an effective code. When the chosen crystal has a fault flag pending, the effective code names a substitute source instead. The low-frequency crystal is replaced by the internal 32 kHz reference. Either high-frequency crystal is replaced by the DCO.

There are four oscillators under watch: the DCO, the low-frequency crystal, the high-frequency crystal and the second crystal. Each has a fault input, and each has its own sticky flag. A combined flag summarises the four. A flag stays set until software clears it while the oscillator is healthy. Clearing the flag removes the substitution, so the software choice comes back. Crystals do not oscillate the moment power is applied, so the low-frequency crystal's flag is already set when reset ends.

The block also takes a requested low-power mode and the clock requests raised by a set of peripherals. From these it reports which clocks may actually be gated. A clock that any peripheral still needs is never gated. The glitch-free switching circuitry downstream is not part of this block.

Top module: `osc_failsafe_sel`

## Requirements
- R1: After reset the auxiliary select holds code 0 (low-frequency crystal). The main and subsystem selects hold code 4 (DCO divided by 2). The flags read 4'b0010, where bit 0 is the DCO, bit 1 the low-frequency crystal, bit 2 the high-frequency crystal and bit 3 the second crystal. The combined flag reads 1.
- R2: When `sel_we_i[k]` is high at a clock edge, `sel_wdata_i` is loaded into the select of clock k (0 auxiliary, 1 main, 2 subsystem). When no substitution applies, the result appears on `eff_sel_o[3k+2:3k]` after that edge.
- R3: A select of code 0 (low-frequency crystal) resolves to code 2 (internal 32 kHz reference) whenever flag bit 1 is set.
- R4: A select of code 5 (high-frequency crystal) resolves to code 3 (DCO) while flag bit 2 is set. A select of code 6 (second crystal) resolves to code 3 while flag bit 3 is set. A select of code 3 is never substituted, even while flag bit 0 is set.
- R5: A high `fault_i[i]` at a clock edge sets flag i after that edge. The flag stays set after the fault input falls.
- R6: A high `flag_clr_i[i]` with `fault_i[i]` low clears flag i at that edge. The software-selected source then appears again on the effective select.
- R7: A high `flag_clr_i[i]` while `fault_i[i]` is high is ignored, and flag i stays set.
- R8: `any_fault_o` becomes 1 at the same edge as any individual flag. `any_clr_i` clears it only if all individual flags are clear after that edge. Otherwise it stays at 1.
- R9: `lpm_i` maps to a gate mask on `gate_o` (bit 0 auxiliary, bit 1 main, bit 2 subsystem), combinationally. Mode 0 gives 3'b000, mode 1 gives 3'b010, mode 2 gives 3'b110 and mode 3 gives 3'b111.
- R10: Each peripheral p drives `periph_req_i[3p+k]` to request clock k. While any peripheral requests clock k, `gate_o[k]` is 0 whatever the mode.
- R11: Select code 7 is reserved and resolves to code 4. Code 1 is the very-low-power internal oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 3 | Per-clock select write strobes |
| sel_wdata_i | input | 3 | Source code to write |
| fault_i | input | 4 | Oscillator fault inputs (DCO, LF crystal, HF crystal, second crystal) |
| flag_clr_i | input | 4 | Per-oscillator flag clear strobes |
| any_clr_i | input | 1 | Combined flag clear strobe |
| periph_req_i | input | 3*NUM_REQ | Peripheral clock requests, three bits per peripheral |
| lpm_i | input | 2 | Requested low-power mode |
| eff_sel_o | output | 9 | Effective source code for each clock, three bits each |
| flags_o | output | 4 | Sticky per-oscillator fault flags |
| any_fault_o | output | 1 | Combined oscillator fault flag |
| gate_o | output | 3 | Clocks permitted to be gated |

## Verification
Two actions can fall on the same edge: a flag clear and a still-active fault on the same oscillator. The bench raises both on one edge and expects the flag to stay set and the fallback code to remain on the effective select. A second collision pairs a combined-flag clear with an individual flag that is still pending. The bench expects the combined flag to stay at 1 until the individual flag is gone. Gate arbitration is judged by pairing a mode that gates a clock with a peripheral request for that same clock, and by expecting that clock's gate bit to drop.

// File: rtl/osc_fs_pkg.sv
package osc_fs_pkg;

   localparam int SEL_W   = 3;
   localparam int NUM_CLK = 3;
   localparam int NUM_OSC = 4;

   localparam int OSC_DCO  = 0;
   localparam int OSC_LF   = 1;
   localparam int OSC_HF   = 2;
   localparam int OSC_XT2  = 3;

   typedef enum logic [SEL_W-1:0] {
      SRC_LFXT   = 3'd0,
      SRC_SLOWRC = 3'd1,
      SRC_REF32  = 3'd2,
      SRC_DCO    = 3'd3,
      SRC_DCODIV = 3'd4,
      SRC_HFXT   = 3'd5,
      SRC_XT2    = 3'd6,
      SRC_RSVD   = 3'd7
   } src_e;

   // Reset choice per clock: 0 auxiliary, 1 main, 2 subsystem
   function automatic logic [SEL_W-1:0] default_sel(input int k);
      return (k == 0) ? SRC_LFXT : SRC_DCODIV;
   endfunction

   function automatic logic [SEL_W-1:0] resolve(input logic [SEL_W-1:0] sel,
                                                input logic [NUM_OSC-1:0] flags);
      logic [SEL_W-1:0] r;
      case (sel)
         SRC_LFXT: r = flags[OSC_LF]  ? SRC_REF32 : SRC_LFXT;
         SRC_HFXT: r = flags[OSC_HF]  ? SRC_DCO   : SRC_HFXT;
         SRC_XT2:  r = flags[OSC_XT2] ? SRC_DCO   : SRC_XT2;
         SRC_RSVD: r = SRC_DCODIV;
         default:  r = sel;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/osc_fault_flags.sv
module osc_fault_flags
   import osc_fs_pkg::*;
#(
   parameter logic [NUM_OSC-1:0] RST_FLAGS = 4'b0010
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_OSC-1:0] fault_i,
   input  logic [NUM_OSC-1:0] clr_i,
   input  logic               any_clr_i,
   output logic [NUM_OSC-1:0] flags_o,
   output logic               any_o
);

   logic [NUM_OSC-1:0] flags_q, flags_d;
   logic               any_q, any_d;

   always_comb begin
      flags_d = (flags_q & ~(clr_i & ~fault_i)) | fault_i;
      any_d   = (any_q & ~any_clr_i) | (|flags_d);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= RST_FLAGS;
         any_q   <= |RST_FLAGS;
      end else begin
         flags_q <= flags_d;
         any_q   <= any_d;
      end
   end

   assign flags_o = flags_q;
   assign any_o   = any_q;

   for (genvar i = 0; i < NUM_OSC; i++) begin : g_chk
      assert_fault_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         fault_i[i] |=> flags_q[i]);
      assert_clear_works_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[i] && !fault_i[i]) |=> !flags_q[i]);
      assert_clear_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[i] && fault_i[i]) |=> flags_q[i]);
   end

   assert_any_covers_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|flags_q) |-> any_q);

endmodule

// File: rtl/osc_src_resolve.sv
module osc_src_resolve
   import osc_fs_pkg::*;
(
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [NUM_OSC-1:0] flags_i,
   output logic [SEL_W-1:0]   eff_o
);

   always_comb eff_o = resolve(sel_i, flags_i);

   always_comb begin
      assert_lf_substituted_R3: assert (!(flags_i[OSC_LF] && eff_o == SRC_LFXT));
      assert_hf_substituted_R4: assert (!(flags_i[OSC_HF] && eff_o == SRC_HFXT)
                                        && !(flags_i[OSC_XT2] && eff_o == SRC_XT2));
      assert_no_reserved_R11: assert (eff_o != SRC_RSVD);
   end

endmodule

// File: rtl/clk_gate_arbiter.sv
module clk_gate_arbiter
   import osc_fs_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic [1:0]               lpm_i,
   input  logic [NUM_REQ*NUM_CLK-1:0] req_i,
   output logic [NUM_CLK-1:0]        gate_o
);

   logic [NUM_CLK-1:0] needed;
   logic [NUM_CLK-1:0] mode_mask;

   for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
      logic [NUM_REQ-1:0] col;
      for (genvar p = 0; p < NUM_REQ; p++) begin : g_per
         assign col[p] = req_i[p*NUM_CLK + k];
      end
      assign needed[k] = |col;
   end

   always_comb begin
      case (lpm_i)
         2'd0:    mode_mask = 3'b000;
         2'd1:    mode_mask = 3'b010;
         2'd2:    mode_mask = 3'b110;
         default: mode_mask = 3'b111;
      endcase
      gate_o = mode_mask & ~needed;
   end

   always_comb begin
      assert_request_vetoes_R10: assert ((gate_o & needed) == '0);
      assert_active_no_gate_R9: assert (lpm_i != 2'd0 || gate_o == '0);
   end

endmodule

// File: rtl/osc_failsafe_sel.sv
module osc_failsafe_sel
   import osc_fs_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [2:0]                sel_we_i,
   input  logic [2:0]                sel_wdata_i,
   input  logic [3:0]                fault_i,
   input  logic [3:0]                flag_clr_i,
   input  logic                      any_clr_i,
   input  logic [NUM_REQ*3-1:0]      periph_req_i,
   input  logic [1:0]                lpm_i,
   output logic [8:0]                eff_sel_o,
   output logic [3:0]                flags_o,
   output logic                      any_fault_o,
   output logic [2:0]                gate_o
);

   if (NUM_REQ < 1) begin : g_bad_req
      $error("NUM_REQ must be at least 1");
   end

   logic [NUM_OSC-1:0] flags;

   osc_fault_flags #(.RST_FLAGS(4'b0010)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fault_i   (fault_i),
      .clr_i     (flag_clr_i),
      .any_clr_i (any_clr_i),
      .flags_o   (flags),
      .any_o     (any_fault_o)
   );

   assign flags_o = flags;

   for (genvar k = 0; k < NUM_CLK; k++) begin : g_sel
      logic [SEL_W-1:0] sel_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          sel_q <= default_sel(k);
         else if (sel_we_i[k]) sel_q <= sel_wdata_i;
      end

      osc_src_resolve u_res (
         .sel_i   (sel_q),
         .flags_i (flags),
         .eff_o   (eff_sel_o[k*SEL_W +: SEL_W])
      );

      assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sel_we_i[k] && sel_wdata_i == SRC_DCODIV) |=> eff_sel_o[k*SEL_W +: SEL_W] == SRC_DCODIV);
   end

   clk_gate_arbiter #(.NUM_REQ(NUM_REQ)) u_gate (
      .lpm_i  (lpm_i),
      .req_i  (periph_req_i),
      .gate_o (gate_o)
   );

endmodule

// File: tb/osc_failsafe_sel_bench.sv
module osc_failsafe_sel_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NREQ = 4;

   logic             clk = 0;
   logic             rst_n = 0;
   logic [2:0]       sel_we = 0;
   logic [2:0]       sel_wdata = 0;
   logic [3:0]       fault = 0;
   logic [3:0]       flag_clr = 0;
   logic             any_clr = 0;
   logic [NREQ*3-1:0] preq = 0;
   logic [1:0]       lpm = 0;
   logic [8:0]       eff;
   logic [3:0]       flags;
   logic             anyf;
   logic [2:0]       gate;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   osc_failsafe_sel #(.NUM_REQ(NREQ)) u_osc_failsafe_sel (
      .clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata),
      .fault_i(fault), .flag_clr_i(flag_clr), .any_clr_i(any_clr),
      .periph_req_i(preq), .lpm_i(lpm), .eff_sel_o(eff), .flags_o(flags),
      .any_fault_o(anyf), .gate_o(gate)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      sel_we = 0; flag_clr = 0; any_clr = 0;
   endtask

   task automatic write_sel(input int k, input logic [2:0] code);
      sel_we = 3'b001 << k; sel_wdata = code;
      step();
   endtask

   task automatic t_reset();
      check("R1 aux eff (fallback)", eff[2:0], 2);
      check("R1 main eff", eff[5:3], 4);
      check("R1 sub eff", eff[8:6], 4);
      check("R1 flags", flags, 4'b0010);
      check("R1 any", anyf, 1);
      check("R9 gate mode0", gate, 0);
   endtask

   task automatic t_clear_lf();
      flag_clr = 4'b0010; step();
      check("R6 lf flag cleared", flags, 0);
      check("R6 aux restored", eff[2:0], 0);
      check("R8 any sticky", anyf, 1);
      any_clr = 1; step();
      check("R8 any cleared", anyf, 0);
   endtask

   task automatic t_fault_lf();
      fault = 4'b0010; step();
      fault = 0;
      check("R5 lf flag set", flags, 4'b0010);
      check("R8 any same edge", anyf, 1);
      check("R3 aux to ref32", eff[2:0], 2);
      step();
      check("R5 lf flag held", flags, 4'b0010);
   endtask

   task automatic t_clear_collision();
      fault = 4'b0010; flag_clr = 4'b0010; any_clr = 1; step();
      check("R7 clear ignored", flags[1], 1);
      check("R7 aux still fallback", eff[2:0], 2);
      check("R8 any clear ignored", anyf, 1);
      fault = 0;
      any_clr = 1; step();
      check("R8 any held by flag", anyf, 1);
      flag_clr = 4'b0010; step();
      check("R6 cleared after fault gone", flags, 0);
      any_clr = 1; step();
      check("R8 any cleared later", anyf, 0);
   endtask

   task automatic t_high_freq();
      write_sel(1, 3'd5);
      check("R2 main hf", eff[5:3], 5);
      write_sel(2, 3'd6);
      check("R2 sub xt2", eff[8:6], 6);
      fault = 4'b0100; step(); fault = 0;
      check("R4 main to dco", eff[5:3], 3);
      check("R4 sub unaffected", eff[8:6], 6);
      fault = 4'b1000; step(); fault = 0;
      check("R4 sub to dco", eff[8:6], 3);
      write_sel(0, 3'd3);
      fault = 4'b0001; step(); fault = 0;
      check("R4 dco flag set", flags[0], 1);
      check("R4 dco not substituted", eff[2:0], 3);
      flag_clr = 4'b1111; step();
      check("R6 all flags clear", flags, 0);
      check("R6 main restored", eff[5:3], 5);
      check("R6 sub restored", eff[8:6], 6);
      write_sel(0, 3'd7);
      check("R11 reserved code", eff[2:0], 4);
      write_sel(0, 3'd1);
      check("R2 aux slow rc", eff[2:0], 1);
   endtask

   task automatic t_gating();
      preq = 0;
      for (int m = 0; m < 4; m++) begin
         lpm = m[1:0]; #1;
         case (m)
            0: check("R9 mode0", gate, 3'b000);
            1: check("R9 mode1", gate, 3'b010);
            2: check("R9 mode2", gate, 3'b110);
            default: check("R9 mode3", gate, 3'b111);
         endcase
      end
      lpm = 2; preq[2*3+2] = 1; #1;
      check("R10 sub request vetoes", gate, 3'b010);
      lpm = 3; preq = 0; preq[0*3+0] = 1; #1;
      check("R10 aux request vetoes", gate, 3'b110);
      preq[3*3+1] = 1; #1;
      check("R10 main request vetoes", gate, 3'b100);
      preq = 0; lpm = 0; #1;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_clear_lf();
      t_fault_lf();
      t_clear_collision();
      t_high_freq();
      t_gating();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule